// File: doc/BRIEF.md
# Microwire EEPROM Station-Address Loader

This block fetches a 48-bit station (MAC) address from a three-wire serial configuration EEPROM when the chip comes out of reset, with no processor involved. It drives chip select, shift clock and serial data toward the memory, and it samples the memory's serial output. The first read goes to word 0 with an 8-bit address field. If that word holds the identifier 0x8129, the part is taken to be an 8-bit-address device. Otherwise every later read uses a 6-bit address field. The loader then reads words 7, 8 and 9 and packs their bytes, low byte first, into the address.

After the address is loaded, the block serves single-word reads through a small request port. A request carries a start strobe, a 3-bit opcode and an address. The block answers with a busy level, a one-cycle done strobe and the 16-bit word. Only the read opcode starts an access. Each phase of the shift clock lasts a programmable number of system clocks.

The serial engine walks the states IDLE, CS_LOW, CS_HIGH, CMD_LO, CMD_HI, GAP, DAT_HI, DAT_LO, END and DONE. It leaves IDLE on go, loops CMD_HI to CMD_LO until the last command bit has been sent, and loops DAT_LO to DAT_HI until the last data bit has been taken. Every other transition fires on a phase tick, except DONE, which returns to IDLE after one clock. The sequencer walks ISSUE, then WAIT, then back to ISSUE for each of the four boot words, and then moves to READY. From READY, an accepted request leads to USER, then UDONE, then READY again.

Top module: `mw_mac_loader`

## Requirements
- R1: After reset the first access reads word 0 using 8 address bits. `addr_wide` becomes 1 if the 16-bit result equals 0x8129 and 0 otherwise, and later accesses use 8 or 6 address bits to match.
- R2: Each access begins with a read command sent on `ee_di` MSB first: the 3 bits 1,1,0 followed by the address (8 or 6 bits). That is 3 plus the address width command bits, and `ee_di` is 0 during the data clocks.
- R3: Each command bit is placed on `ee_di` while `ee_sk` is low, and `ee_di` does not change while `ee_sk` is high.
- R4: After the command, exactly 16 further `ee_sk` high pulses occur. `ee_do` is sampled late in each high phase, and the first sampled bit becomes bit 15 of the word.
- R5: `ee_cs` is low when an access begins and is raised at least one full phase before the first `ee_sk` rise. It is dropped after the last data bit. `ee_sk` is never high while `ee_cs` is low.
- R6: The address comes from words 7, 8 and 9, read in that order. `mac_addr[47:40]` = word7[7:0], `[39:32]` = word7[15:8], `[31:24]` = word8[7:0], `[23:16]` = word8[15:8], `[15:8]` = word9[7:0] and `[7:0]` = word9[15:8]. `mac_valid` rises once all three words are in and stays high until reset.
- R7: Every `ee_sk` high phase lasts exactly PHASE_CYCLES clocks. Every low phase between two high phases of one access also lasts exactly PHASE_CYCLES clocks.
- R8: While `rd_busy` is 0, a `rd_start` with `rd_op` = 3'b110 reads the word at `rd_addr`. In 6-bit mode only `rd_addr[5:0]` is used. The word appears on `rd_data` while `rd_done` is high.
- R9: `rd_done` is high for exactly one clock and only after `ee_cs` has dropped. `rd_busy` is high from reset until `mac_valid` rises, and from an accepted request through the done cycle inclusive. It is low in the cycle after done.
- R10: A `rd_start` while `rd_busy` is high is ignored: no extra access takes place, and the running read returns its own word.
- R11: A `rd_start` with any `rd_op` other than 3'b110 (for example write 3'b101 or erase 3'b111) is ignored: `ee_cs` stays low and `rd_busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| rd_start | input | 1 | Single-word read request strobe |
| rd_op | input | 3 | Request opcode; only 3'b110 is acted on |
| rd_addr | input | ADDR_MAX | Word address of the request |
| rd_busy | output | 1 | Boot or request in progress |
| rd_done | output | 1 | One-cycle completion strobe |
| rd_data | output | 16 | Word returned by the last request |
| mac_addr | output | 48 | Assembled station address |
| mac_valid | output | 1 | Station address loaded |
| addr_wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |

## Verification
The bench runs two memory models. One is an 8-bit part holding the identifier. The other is a 6-bit part that receives the 8-bit identifier read misaligned. A loader that mishandled that misalignment, or compared the wrong bits, would set the wrong width. Every later command would then carry the wrong bit count, which the model's edge count exposes. The bench also checks byte order within each address word, since a swap there still yields a plausible address. Upper address bits in 6-bit mode must be dropped, or the request reaches the wrong word. Further checks cover requests made while busy or with write or erase opcodes, which a careless port would execute or queue. Phase widths and data stability while the clock is high are also measured, to catch an off-by-one divider or data that changes on the rising edge.

// File: rtl/mw_loader_pkg.sv
package mw_loader_pkg;

    typedef enum logic [3:0] {
        E_IDLE,
        E_CS_LOW,
        E_CS_HIGH,
        E_CMD_LO,
        E_CMD_HI,
        E_GAP,
        E_DAT_HI,
        E_DAT_LO,
        E_END,
        E_DONE
    } eng_state_t;

    typedef enum logic [2:0] {
        B_ISSUE,
        B_WAIT,
        B_READY,
        B_USER,
        B_UDONE
    } boot_state_t;

    localparam logic [2:0]  OP_READ   = 3'b110;
    localparam logic [15:0] WIDE_ID   = 16'h8129;
    localparam int          WORD_W    = 16;
    localparam int          OP_W      = 3;
    localparam int          MAC_FIRST = 7;
    localparam int          MAC_WORDS = 3;

endpackage

// File: rtl/mw_phase_div.sv
module mw_phase_div #(
    parameter int PHASE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    generate
        if (PHASE_CYCLES > 1) begin : g_tick_spacing
            assert_tick_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
    import mw_loader_pkg::*;
#(
    parameter int ADDR_MAX = 8,
    parameter int NARROW_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                go,
    input  logic                wide,
    input  logic [ADDR_MAX-1:0] addr,
    input  logic                ee_do,
    output logic                ee_cs,
    output logic                ee_sk,
    output logic                ee_di,
    output logic                div_clr,
    output logic                done,
    output logic [WORD_W-1:0]   data
);
    localparam int CMD_W  = OP_W + ADDR_MAX;
    localparam int NCMD_W = OP_W + NARROW_W;
    localparam int MAXC   = (CMD_W > WORD_W) ? CMD_W : WORD_W;
    localparam int CNT_W  = $clog2(MAXC);

    eng_state_t        state, nxt;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CNT_W-1:0]  bits_left;
    logic [WORD_W-1:0] data_sr;
    logic              last_bit;

    assign last_bit = (bits_left == '0);
    assign data     = data_sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            E_IDLE:    if (go)   nxt = E_CS_LOW;
            E_CS_LOW:  if (tick) nxt = E_CS_HIGH;
            E_CS_HIGH: if (tick) nxt = E_CMD_LO;
            E_CMD_LO:  if (tick) nxt = E_CMD_HI;
            E_CMD_HI:  if (tick) nxt = last_bit ? E_GAP : E_CMD_LO;
            E_GAP:     if (tick) nxt = E_DAT_HI;
            E_DAT_HI:  if (tick) nxt = E_DAT_LO;
            E_DAT_LO:  if (tick) nxt = last_bit ? E_END : E_DAT_HI;
            E_END:     if (tick) nxt = E_DONE;
            E_DONE:              nxt = E_IDLE;
            default:             nxt = E_IDLE;
        endcase
    end

    // shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_sr    <= '0;
            bits_left <= '0;
            data_sr   <= '0;
        end else if (state == E_IDLE && go) begin
            if (wide) begin
                cmd_sr    <= {OP_READ, addr};
                bits_left <= CNT_W'(CMD_W - 1);
            end else begin
                cmd_sr    <= {OP_READ, addr[NARROW_W-1:0], {(ADDR_MAX-NARROW_W){1'b0}}};
                bits_left <= CNT_W'(NCMD_W - 1);
            end
        end else if (tick) begin
            if (state == E_CMD_HI) begin
                cmd_sr    <= cmd_sr << 1;
                bits_left <= last_bit ? CNT_W'(WORD_W - 1) : bits_left - 1'b1;
            end else if (state == E_DAT_HI) begin
                data_sr   <= {data_sr[WORD_W-2:0], ee_do};
            end else if (state == E_DAT_LO && !last_bit) begin
                bits_left <= bits_left - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ee_cs   = 1'b0;
        ee_sk   = 1'b0;
        ee_di   = 1'b0;
        done    = 1'b0;
        div_clr = 1'b0;
        unique case (state)
            E_IDLE:    div_clr = 1'b1;
            E_CS_LOW:  ;
            E_CS_HIGH: ee_cs = 1'b1;
            E_CMD_LO:  begin ee_cs = 1'b1; ee_di = cmd_sr[CMD_W-1]; end
            E_CMD_HI:  begin ee_cs = 1'b1; ee_sk = 1'b1; ee_di = cmd_sr[CMD_W-1]; end
            E_GAP:     ee_cs = 1'b1;
            E_DAT_HI:  begin ee_cs = 1'b1; ee_sk = 1'b1; end
            E_DAT_LO:  ee_cs = 1'b1;
            E_END:     ;
            E_DONE:    begin done = 1'b1; div_clr = 1'b1; end
            default:   div_clr = 1'b1;
        endcase
    end

    assert_sk_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    assert_di_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    assert_done_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ee_cs && !$past(ee_cs)));

endmodule

// File: rtl/mw_boot_ctrl.sv
module mw_boot_ctrl
    import mw_loader_pkg::*;
#(
    parameter int ADDR_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eng_done,
    input  logic [WORD_W-1:0]   eng_data,
    input  logic                rd_start,
    input  logic [OP_W-1:0]     rd_op,
    input  logic [ADDR_MAX-1:0] rd_addr,
    output logic                eng_go,
    output logic                eng_wide,
    output logic [ADDR_MAX-1:0] eng_addr,
    output logic [47:0]         mac_addr,
    output logic                mac_valid,
    output logic                addr_wide,
    output logic                rd_busy,
    output logic                rd_done,
    output logic [WORD_W-1:0]   rd_data
);
    boot_state_t       state, nxt;
    logic [1:0]        idx;
    logic              wide_r;
    logic              valid_r;
    logic [47:0]       mac_r;
    logic [WORD_W-1:0] rdata_r;
    logic              accept;

    assign accept    = rd_start && (rd_op == OP_READ);
    assign mac_addr  = mac_r;
    assign mac_valid = valid_r;
    assign addr_wide = wide_r;
    assign rd_data   = rdata_r;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_ISSUE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            B_ISSUE: nxt = B_WAIT;
            B_WAIT:  if (eng_done) nxt = (idx == 2'(MAC_WORDS)) ? B_READY : B_ISSUE;
            B_READY: if (accept)   nxt = B_USER;
            B_USER:  if (eng_done) nxt = B_UDONE;
            B_UDONE: nxt = B_READY;
            default: nxt = B_ISSUE;
        endcase
    end

    // captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx     <= '0;
            wide_r  <= 1'b0;
            valid_r <= 1'b0;
            mac_r   <= '0;
            rdata_r <= '0;
        end else begin
            if (state == B_WAIT && eng_done) begin
                unique case (idx)
                    2'd0: wide_r         <= (eng_data == WIDE_ID);
                    2'd1: mac_r[47:32]   <= {eng_data[7:0], eng_data[15:8]};
                    2'd2: mac_r[31:16]   <= {eng_data[7:0], eng_data[15:8]};
                    2'd3: mac_r[15:0]    <= {eng_data[7:0], eng_data[15:8]};
                    default: ;
                endcase
                idx <= idx + 1'b1;
                if (idx == 2'(MAC_WORDS)) valid_r <= 1'b1;
            end
            if (state == B_USER && eng_done) rdata_r <= eng_data;
        end
    end

    // outputs
    always_comb begin
        eng_go   = 1'b0;
        eng_wide = wide_r;
        eng_addr = rd_addr;
        rd_busy  = 1'b1;
        rd_done  = 1'b0;
        unique case (state)
            B_ISSUE: begin
                eng_go   = 1'b1;
                eng_wide = (idx == 2'd0) ? 1'b1 : wide_r;
                eng_addr = (idx == 2'd0) ? '0
                         : ADDR_MAX'(MAC_FIRST) + ADDR_MAX'(idx) - 1'b1;
            end
            B_WAIT:  ;
            B_READY: begin rd_busy = 1'b0; eng_go = accept; end
            B_USER:  ;
            B_UDONE: rd_done = 1'b1;
            default: ;
        endcase
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    assert_busy_through_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> rd_busy);

    assert_busy_until_mac_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_valid |-> rd_busy);

    assert_mac_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |=> (mac_valid && $stable(mac_addr)));

endmodule

// File: rtl/mw_mac_loader.sv
module mw_mac_loader
    import mw_loader_pkg::*;
#(
    parameter int PHASE_CYCLES = 50,
    parameter int ADDR_MAX     = 8,
    parameter int NARROW_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                ee_cs,
    output logic                ee_sk,
    output logic                ee_di,
    input  logic                ee_do,
    input  logic                rd_start,
    input  logic [2:0]          rd_op,
    input  logic [ADDR_MAX-1:0] rd_addr,
    output logic                rd_busy,
    output logic                rd_done,
    output logic [15:0]         rd_data,
    output logic [47:0]         mac_addr,
    output logic                mac_valid,
    output logic                addr_wide
);
    logic                tick;
    logic                div_clr;
    logic                eng_go;
    logic                eng_wide;
    logic [ADDR_MAX-1:0] eng_addr;
    logic                eng_done;
    logic [WORD_W-1:0]   eng_data;

    mw_phase_div #(
        .PHASE_CYCLES(PHASE_CYCLES)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .tick (tick)
    );

    mw_word_reader #(
        .ADDR_MAX(ADDR_MAX),
        .NARROW_W(NARROW_W)
    ) u_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .go     (eng_go),
        .wide   (eng_wide),
        .addr   (eng_addr),
        .ee_do  (ee_do),
        .ee_cs  (ee_cs),
        .ee_sk  (ee_sk),
        .ee_di  (ee_di),
        .div_clr(div_clr),
        .done   (eng_done),
        .data   (eng_data)
    );

    mw_boot_ctrl #(
        .ADDR_MAX(ADDR_MAX)
    ) u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_done (eng_done),
        .eng_data (eng_data),
        .rd_start (rd_start),
        .rd_op    (rd_op),
        .rd_addr  (rd_addr),
        .eng_go   (eng_go),
        .eng_wide (eng_wide),
        .eng_addr (eng_addr),
        .mac_addr (mac_addr),
        .mac_valid(mac_valid),
        .addr_wide(addr_wide),
        .rd_busy  (rd_busy),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/mw_mac_loader_bench.sv
module mw_mac_loader_bench;
    localparam int PH = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;
    logic        rd_start = 1'b0;
    logic [2:0]  rd_op = 3'b000;
    logic [7:0]  rd_addr = 8'h00;
    logic        rd_busy, rd_done, mac_valid, addr_wide;
    logic [15:0] rd_data;
    logic [47:0] mac_addr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mw_mac_loader #(.PHASE_CYCLES(PH)) u_mw_mac_loader (
        .clk(clk), .rst_n(rst_n),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .rd_start(rd_start), .rd_op(rd_op), .rd_addr(rd_addr),
        .rd_busy(rd_busy), .rd_done(rd_done), .rd_data(rd_data),
        .mac_addr(mac_addr), .mac_valid(mac_valid), .addr_wide(addr_wide)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [0:255];
    int          model_aw = 8;
    int          edges;
    int          accesses = 0;
    int          out_ptr;
    logic [15:0] cmd_rx;
    logic [15:0] out_word;
    logic [63:0] rx_bits;

    always @(posedge ee_cs) begin
        edges = 0; cmd_rx = '0; rx_bits = '0; out_ptr = -1;
        accesses = accesses + 1;
    end
    always @(negedge ee_cs) ee_do = 1'b0;

    always @(posedge ee_sk) if (ee_cs) begin
        edges = edges + 1;
        rx_bits = {rx_bits[62:0], ee_di};
        if (edges <= 3 + model_aw) begin
            cmd_rx = {cmd_rx[14:0], ee_di};
            if (edges == 3 + model_aw) begin
                out_word = mem[cmd_rx & 16'((1 << model_aw) - 1)];
                out_ptr = 15;
            end
        end else begin
            ee_do = (out_ptr >= 0) ? out_word[out_ptr] : 1'b0;
            out_ptr = out_ptr - 1;
        end
    end

    // ---------------- waveform monitors ----------------
    logic prev_sk = 1'b0, prev_cs = 1'b0, prev_di = 1'b0;
    int hi_run = 0, lo_run = 0, hi_min, hi_max, lo_min, lo_max;
    int since_cs = 0, cs_to_sk = 0, bad_sk = 0, bad_di = 0;
    bit first_pend = 0, had_hi = 0;

    task automatic clear_meas();
        hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30; lo_max = 0;
        bad_sk = 0; bad_di = 0; cs_to_sk = 1 << 30;
    endtask

    always @(negedge clk) begin
        if (ee_sk && !ee_cs) bad_sk++;
        if (ee_sk && prev_sk && ee_di !== prev_di) bad_di++;
        if (ee_cs && !prev_cs) begin since_cs = 0; first_pend = 1; had_hi = 0; end
        if (ee_cs) since_cs++;
        if (ee_sk && !prev_sk) begin
            if (first_pend) begin
                if (since_cs < cs_to_sk) cs_to_sk = since_cs;
                first_pend = 0;
            end
            if (had_hi) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            hi_run = 0;
        end
        if (!ee_sk && prev_sk) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            had_hi = 1; lo_run = 0;
        end
        if (ee_sk) hi_run++; else lo_run++;
        prev_sk = ee_sk; prev_cs = ee_cs; prev_di = ee_di;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_mac();
        return {mem[7][7:0], mem[7][15:8], mem[8][7:0], mem[8][15:8],
                mem[9][7:0], mem[9][15:8]};
    endfunction

    function automatic logic [63:0] exp_cmd(input int aw, input int a);
        return 64'(((6 << aw) | (a & ((1 << aw) - 1)))) << 16;
    endfunction

    task automatic do_reset(input int aw, input logic [15:0] id);
        rst_n = 1'b0;
        model_aw = aw;
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h9E37) ^ 16'hA5C3);
        mem[0] = id;
        clear_meas();
        repeat (4) @(negedge clk);
        chk("R9 reset cs", {63'd0, ee_cs}, 64'd0);
        chk("R9 reset busy", {63'd0, rd_busy}, 64'd1);
        chk("R6 reset valid", {63'd0, mac_valid}, 64'd0);
        chk("R5 reset sk", {63'd0, ee_sk}, 64'd0);
        accesses = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 20000 && !mac_valid; i++) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_boot(input int aw);
        wait_valid();
        chk("R1 addr_wide", {63'd0, addr_wide}, (aw == 8) ? 64'd1 : 64'd0);
        chk("R6 mac_addr", {16'd0, mac_addr}, {16'd0, exp_mac()});
        chk("R6 access count", 64'(accesses), 64'd4);
        chk("R2 last boot command", rx_bits, exp_cmd(aw, 9));
        chk("R4 last boot edges", 64'(edges), 64'(3 + aw + 16));
        chk("R7 high min", 64'(hi_min), 64'(PH));
        chk("R7 high max", 64'(hi_max), 64'(PH));
        chk("R7 low min", 64'(lo_min), 64'(PH));
        chk("R7 low max", 64'(lo_max), 64'(PH));
        chk("R5 cs lead over one phase", {63'd0, (cs_to_sk > PH)}, 64'd1);
        chk("R5 sk outside cs", 64'(bad_sk), 64'd0);
        chk("R3 di changed while sk high", 64'(bad_di), 64'd0);
        @(negedge clk);
        chk("R9 busy after boot", {63'd0, rd_busy}, 64'd0);
    endtask

    task automatic t_user_read(input logic [7:0] a, input int aw);
        int n0, cyc;
        logic [15:0] expw;
        expw = mem[(aw == 8) ? a : {2'b00, a[5:0]}];
        n0 = accesses;
        rd_addr = a; rd_op = 3'b110; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0; rd_addr = ~a;
        chk("R9 busy after accept", {63'd0, rd_busy}, 64'd1);
        cyc = 0;
        while (!rd_done && cyc < 10000) begin @(negedge clk); cyc++; end
        chk("R8 read data", {48'd0, rd_data}, {48'd0, expw});
        chk("R9 cs low at done", {63'd0, ee_cs}, 64'd0);
        chk("R9 busy at done", {63'd0, rd_busy}, 64'd1);
        chk("R2 user command", rx_bits, exp_cmd(aw, int'(a)));
        chk("R4 user edges", 64'(edges), 64'(3 + aw + 16));
        chk("R8 one access", 64'(accesses - n0), 64'd1);
        @(negedge clk);
        chk("R9 done one cycle", {63'd0, rd_done}, 64'd0);
        chk("R9 busy low after done", {63'd0, rd_busy}, 64'd0);
    endtask

    task automatic t_busy_ignore();
        int n0, cyc;
        n0 = accesses;
        rd_addr = 8'h21; rd_op = 3'b110; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        repeat (3 * PH) @(negedge clk);
        rd_addr = 8'h44; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        cyc = 0;
        while (!rd_done && cyc < 10000) begin @(negedge clk); cyc++; end
        chk("R10 data of first request", {48'd0, rd_data}, {48'd0, mem[8'h21]});
        repeat (6 * PH) @(negedge clk);
        chk("R10 no extra access", 64'(accesses - n0), 64'd1);
        chk("R10 idle after", {63'd0, rd_busy}, 64'd0);
    endtask

    task automatic t_bad_op(input logic [2:0] op);
        int n0;
        n0 = accesses;
        rd_addr = 8'h12; rd_op = op; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        chk("R11 busy stays low", {63'd0, rd_busy}, 64'd0);
        repeat (3 * PH) @(negedge clk);
        chk("R11 cs stays low", {63'd0, ee_cs}, 64'd0);
        chk("R11 no access", 64'(accesses - n0), 64'd0);
        rd_op = 3'b000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // 8-bit part carrying the identifier
        do_reset(8, 16'h8129);
        t_boot(8);
        clear_meas();
        t_user_read(8'h85, 8);
        t_user_read(8'h00, 8);
        t_busy_ignore();
        t_bad_op(3'b101);
        t_bad_op(3'b111);
        // 6-bit part: identifier read arrives misaligned and must not match
        do_reset(6, 16'h2040);
        t_boot(6);
        t_user_read(8'h3F, 6);
        t_user_read(8'hC5, 6);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule